// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device side of a small serial EEPROM of 64 words by 16 bits, built as synthesizable logic clocked by a fast system clock. A host drives chip select, a serial clock and a serial data input. The block samples all three on the system clock and acts on the rising edges of the serial clock. Each instruction is a start bit, a two-bit opcode and a six-bit word address. The write and fill commands then take a sixteen-bit data word.

Read data and the programming status come back on a single serial output. Programming is self-timed. It starts when chip select falls after a complete write, fill, erase or wipe instruction. It then keeps the device busy for a fixed number of system-clock cycles. While the device is busy, it ignores every new instruction. A write-enable latch guards all programming commands. The latch is clear after reset.

Top module: `eep_model`

## Requirements
- R1: While chip select is high and the device is idle, serial-clock rises with data-in low are ignored as leading zeros. The first rise with data-in high is the start bit. The next eight rises carry the opcode (MSB first), then address bits A5..A0.
- R2: READ (opcode 10) drives a dummy 0 from the rise that samples A0. The following sixteen rises shift out D15..D0, MSB first. The output changes just after each rise.
- R3: After reset the write-enable latch is clear, every word holds 16'hFFFF, and the data output is 0.
- R4: Opcode 00 with address bits A5..A4 = 11 sets the write-enable latch. With A5..A4 = 00 it clears the latch. The remaining address bits are don't-care. Neither command changes what READ returns.
- R5: While the latch is clear, WRITE, ERASE, fill and wipe leave memory unchanged, start no programming cycle and show no status.
- R6: WRITE (opcode 01) stores the data bits into the addressed word. When more than sixteen data bits arrive, the last sixteen received are used.
- R7: ERASE (opcode 11) sets the addressed word to 16'hFFFF. Wipe (opcode 00, A5..A4 = 10) sets every word to 16'hFFFF.
- R8: Fill (opcode 00, A5..A4 = 01) writes its sixteen data bits into every word.
- R9: A programming cycle starts only at a chip-select fall after a complete programming instruction. It lasts PROG_CYCLES system-clock cycles. With chip select high, the output then shows 0 while busy and 1 when done.
- R10: With chip select high, a serial-clock rise with data-in high clears the status indication. The output then reads 0.
- R11: Instructions that arrive while a programming cycle runs are ignored.
- R12: A chip-select fall before an instruction is complete aborts it without changing memory or starting a cycle.
- R13: The data output is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host, sampled on clk |
| sdi | input | 1 | Serial data in, sampled at serial-clock rises |
| sdo | output | 1 | Serial data out: read data or ready/busy status |

## Verification
A wrong write-enable latch or a command decode error stays hidden until a later READ returns a word that differs from the expected one. The bench therefore reads back after every programming command and after every command that should be ignored. A wrong busy counter shows on the output within the programming window. The bench samples the status both inside that window and just after it. A decode slip in the serial framing shifts read data by one bit, so the bench uses asymmetric data words that expose it on the first read.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_ARMED,
        ST_READ,
        ST_HOLD
    } ph_e;

    typedef enum logic [1:0] {
        PG_WORD,
        PG_ERASE,
        PG_FILL,
        PG_WIPE
    } pg_e;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;

    localparam logic [1:0] SUB_LOCK    = 2'b00;
    localparam logic [1:0] SUB_FILL    = 2'b01;
    localparam logic [1:0] SUB_WIPE    = 2'b10;
    localparam logic [1:0] SUB_UNLOCK  = 2'b11;
endpackage

// File: rtl/eep_pin_edge.sv
module eep_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs,
    output logic sclk_rise,
    output logic cs_fall
);
    typedef struct packed {
        logic sclk;
        logic cs;
    } pins_t;

    pins_t d, q;

    always_comb begin
        d.sclk = sclk;
        d.cs   = cs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_rise = sclk & ~q.sclk;
    assign cs_fall   = q.cs & ~cs;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CW'(CYCLES - 1);
        end else if (q.busy) begin
            if (q.cnt == '0) d.busy = 1'b0;
            else             d.cnt  = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
endmodule

// File: rtl/eep_word_array.sv
module eep_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              fill,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_d [DEPTH];
    logic [DATA_W-1:0] word_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_comb begin
            word_d[w] = word_q[w];
            if (fill || (we && waddr == ADDR_W'(w))) word_d[w] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[w] <= '1;
            else        word_q[w] <= word_d[w];
        end
    end

    assign rdata = word_q[raddr];
endmodule

// File: rtl/eep_model.sv
module eep_model #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    output logic sdo
);
    import eep_pkg::*;

    localparam int CMD_W = 2 + ADDR_W;
    localparam int CNT_W = $clog2(((DATA_W > CMD_W) ? DATA_W : CMD_W) + 1);

    typedef struct packed {
        ph_e               ph;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        pg_e               pg;
        logic [DATA_W-1:0] wsr;
        logic [DATA_W-1:0] rsr;
        logic [CNT_W-1:0]  rcnt;
        logic              wen;
        logic              show;
        logic              sdo;
    } ctl_t;

    ctl_t d, q;

    logic              sclk_rise, cs_fall, busy;
    logic              prog_start, mem_we, mem_fill;
    logic [CMD_W-1:0]  full_cmd;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data, mem_wdata;
    logic              wen_latch, show_flag;

    eep_pin_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs        (cs),
        .sclk_rise (sclk_rise),
        .cs_fall   (cs_fall)
    );

    eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy)
    );

    eep_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .fill  (mem_fill),
        .waddr (q.addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        d          = q;
        prog_start = 1'b0;
        full_cmd   = {q.cmd[CMD_W-2:0], sdi};
        rd_addr    = full_cmd[ADDR_W-1:0];

        if (!cs) begin
            if (cs_fall && q.wen) begin
                if (q.ph == ST_DATA && q.cnt == CNT_W'(DATA_W)) prog_start = 1'b1;
                if (q.ph == ST_ARMED)                            prog_start = 1'b1;
            end
            if (prog_start) d.show = 1'b1;
            d.ph  = ST_IDLE;
            d.cnt = '0;
            d.sdo = 1'b0;
        end else begin
            if (sclk_rise) begin
                unique case (q.ph)
                    ST_IDLE: begin
                        if (sdi) begin
                            d.show = 1'b0;
                            if (!busy) begin
                                d.ph  = ST_CMD;
                                d.cnt = '0;
                            end
                        end
                    end
                    ST_CMD: begin
                        d.cmd = full_cmd;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(CMD_W - 1)) begin
                            d.cnt  = '0;
                            d.addr = full_cmd[ADDR_W-1:0];
                            unique case (full_cmd[CMD_W-1 -: 2])
                                OPC_READ: begin
                                    d.ph   = ST_READ;
                                    d.rsr  = rd_data;
                                    d.rcnt = CNT_W'(DATA_W);
                                    d.sdo  = 1'b0;
                                end
                                OPC_WRITE: begin
                                    d.ph = ST_DATA;
                                    d.pg = PG_WORD;
                                end
                                OPC_ERASE: begin
                                    d.ph = ST_ARMED;
                                    d.pg = PG_ERASE;
                                end
                                default: begin
                                    unique case (full_cmd[ADDR_W-1 -: 2])
                                        SUB_UNLOCK: begin
                                            d.wen = 1'b1;
                                            d.ph  = ST_HOLD;
                                        end
                                        SUB_LOCK: begin
                                            d.wen = 1'b0;
                                            d.ph  = ST_HOLD;
                                        end
                                        SUB_FILL: begin
                                            d.ph = ST_DATA;
                                            d.pg = PG_FILL;
                                        end
                                        default: begin
                                            d.ph = ST_ARMED;
                                            d.pg = PG_WIPE;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        d.wsr = {q.wsr[DATA_W-2:0], sdi};
                        if (q.cnt != CNT_W'(DATA_W)) d.cnt = q.cnt + 1'b1;
                    end
                    ST_READ: begin
                        if (q.rcnt != '0) begin
                            d.sdo  = q.rsr[DATA_W-1];
                            d.rsr  = {q.rsr[DATA_W-2:0], 1'b0};
                            d.rcnt = q.rcnt - 1'b1;
                        end else begin
                            d.sdo = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (d.ph != ST_READ) d.sdo = d.show & ~busy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= ST_IDLE;
            q.pg <= PG_WORD;
        end else begin
            q <= d;
        end
    end

    assign mem_we    = prog_start && (q.pg == PG_WORD || q.pg == PG_ERASE);
    assign mem_fill  = prog_start && (q.pg == PG_FILL || q.pg == PG_WIPE);
    assign mem_wdata = (q.pg == PG_WORD || q.pg == PG_FILL) ? q.wsr : '1;
    assign wen_latch = q.wen;
    assign show_flag = q.show;
    assign sdo       = q.sdo;
endmodule

// File: rtl/eep_model_chk.sv
module eep_model_chk #(
    parameter int PROG_CYCLES = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sdi,
    input logic sdo,
    input logic sclk_rise,
    input logic prog_start,
    input logic busy,
    input logic wen,
    input logic show
);
    int bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bcnt <= 0;
        else if (prog_start) bcnt <= 0;
        else if (busy)       bcnt <= bcnt + 1;
    end

    AST_SDO_QUIET_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !sdo); // R13

    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen); // R5

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy); // R11

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == PROG_CYCLES); // R9

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy); // R9

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && sclk_rise && sdi) |=> !show); // R10
endmodule

bind eep_model eep_model_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .sdi        (sdi),
    .sdo        (sdo),
    .sclk_rise  (sclk_rise),
    .prog_start (prog_start),
    .busy       (busy),
    .wen        (wen_latch),
    .show       (show_flag)
);

// File: tb/tb_eep_model.sv
module tb_eep_model;
    localparam int PROG = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eep_model #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .sdo(sdo)
    );

    // kind[23:22] (0 write, 1 read-expect, 2 erase), addr[21:16], data[15:0]
    localparam logic [23:0] VEC [9] = '{
        {2'd0, 6'd0,  16'hA5A5},
        {2'd0, 6'd63, 16'h0001},
        {2'd0, 6'd17, 16'h8000},
        {2'd1, 6'd0,  16'hA5A5},
        {2'd1, 6'd63, 16'h0001},
        {2'd1, 6'd17, 16'h8000},
        {2'd2, 6'd17, 16'h0000},
        {2'd1, 6'd17, 16'hFFFF},
        {2'd1, 6'd1,  16'hFFFF}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk); sdi = b;
        repeat (2) @(negedge clk); sclk = 1'b1;
        repeat (2) @(negedge clk); sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic cs_up;
        @(negedge clk); cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_down;
        @(negedge clk); cs = 1'b0; sdi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic instr(input logic [1:0] opc, input logic [5:0] addr);
        cs_up;
        send({23'd0, 1'b1, opc, addr}, 9);
    endtask

    task automatic read_word(input logic [5:0] addr, input int lead, output logic [15:0] w);
        cs_up;
        send(32'd0, lead);
        send({23'd0, 1'b1, 2'b10, addr}, 9);
        chk("R2 dummy bit", {15'd0, sdo}, 16'd0);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            bit_out(1'b0);
            w = {w[14:0], sdo};
        end
        cs_down;
    endtask

    task automatic expect_word(input string tag, input logic [5:0] addr, input logic [15:0] exp);
        logic [15:0] w;
        read_word(addr, 0, w);
        chk(tag, w, exp);
    endtask

    // busy then ready shown, then cleared by a data-in-high rise (R9, R10)
    task automatic status_cycle;
        cs_up;
        chk("R9 busy shows 0", {15'd0, sdo}, 16'd0);
        repeat (PROG + 8) @(negedge clk);
        chk("R9 ready shows 1", {15'd0, sdo}, 16'd1);
        bit_out(1'b1);
        chk("R10 status cleared", {15'd0, sdo}, 16'd0);
        cs_down;
    endtask

    task automatic write_word(input logic [5:0] addr, input logic [15:0] data);
        instr(2'b01, addr);
        send({16'd0, data}, 16);
        cs_down;
        status_cycle;
    endtask

    initial begin
        logic [15:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        chk("R3 sdo after reset", {15'd0, sdo}, 16'd0);
        expect_word("R3 erased after reset", 6'd5, 16'hFFFF);

        // write while latch clear
        instr(2'b01, 6'd3);
        send(32'h1234, 16);
        cs_down;
        cs_up;
        repeat (4) @(negedge clk);
        chk("R5 no status when locked", {15'd0, sdo}, 16'd0);
        cs_down;
        expect_word("R5 locked write ignored", 6'd3, 16'hFFFF);

        // unlock (R4), leading zeros on a read (R1)
        instr(2'b00, 6'b110101);
        cs_down;
        read_word(6'd3, 3, w);
        chk("R1 leading zeros then read", w, 16'hFFFF);

        for (int k = 0; k < 9; k++) begin
            unique case (VEC[k][23:22])
                2'd0: write_word(VEC[k][21:16], VEC[k][15:0]);
                2'd2: begin
                    instr(2'b11, VEC[k][21:16]);
                    cs_down;
                    status_cycle;
                end
                default: expect_word("R6 R7 table read", VEC[k][21:16], VEC[k][15:0]);
            endcase
        end

        // instruction during busy ignored (R11)
        instr(2'b01, 6'd9);
        send(32'h1111, 16);
        cs_down;
        instr(2'b01, 6'd10);
        send(32'h2222, 16);
        cs_down;
        repeat (PROG + 20) @(negedge clk);
        expect_word("R11 busy write ignored", 6'd10, 16'hFFFF);
        expect_word("R6 first write kept", 6'd9, 16'h1111);

        // more than 16 data bits: last 16 kept (R6)
        instr(2'b01, 6'd20);
        send({12'd0, 4'b1010, 16'h5A3C}, 20);
        cs_down;
        status_cycle;
        expect_word("R6 last 16 bits", 6'd20, 16'h5A3C);

        // abort mid data (R12)
        instr(2'b01, 6'd21);
        send(32'h03FF, 10);
        cs_down;
        cs_up;
        repeat (4) @(negedge clk);
        chk("R12 no status after abort", {15'd0, sdo}, 16'd0);
        cs_down;
        expect_word("R12 aborted write", 6'd21, 16'hFFFF);

        // fill all words (R8), output quiet while cs low (R13)
        instr(2'b00, 6'b011010);
        send(32'h0F0F, 16);
        cs_down;
        repeat (PROG + 8) @(negedge clk);
        chk("R13 sdo low with cs low", {15'd0, sdo}, 16'd0);
        cs_up;
        chk("R9 ready after fill", {15'd0, sdo}, 16'd1);
        cs_down;
        expect_word("R8 fill word 0", 6'd0, 16'h0F0F);
        expect_word("R8 fill word 40", 6'd40, 16'h0F0F);

        // wipe all (R7)
        instr(2'b00, 6'b100011);
        cs_down;
        status_cycle;
        expect_word("R7 wipe word 0", 6'd0, 16'hFFFF);
        expect_word("R7 wipe word 63", 6'd63, 16'hFFFF);

        // lock again (R4): write ignored, read still works
        write_word(6'd2, 16'h7777);
        instr(2'b00, 6'b001111);
        cs_down;
        instr(2'b01, 6'd2);
        send(32'h1357, 16);
        cs_down;
        repeat (20) @(negedge clk);
        expect_word("R4 read after lock", 6'd2, 16'h7777);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule